// File: doc/BRIEF.md
# Xon/Xoff Software Flow Control Engine

This block adds in-band flow control to one asynchronous serial channel. On the receive side it inspects every character delivered by the deserializer. It compares each one against four programmed characters: two resume codes and two stop codes. A matching stop code pauses the local transmitter, and a matching resume code lets it run again. Matched flow codes are kept out of the receive FIFO. Two further options exist. One lets any character resume a paused transmitter. The other flags one chosen character with an interrupt without pausing anything.

On the transmit side the block watches the fill level of the local receive FIFO. When the level climbs past a stop threshold, the block asks the serializer to insert a stop code ahead of ordinary data. When the level later falls back to a resume threshold, it asks for a resume code. Inserted codes are trimmed to the active word length. A permission output tells the serializer when it may start shifting the next FIFO data byte. The serializer itself lies outside this block.

Top module: `xonxoff_flow_ctl`

## Requirements
- R1: `mode[1:0]` selects receive matching: 00 = none, every character is pushed and nothing pauses; 01 = compare against `xon_a`/`xoff_a`; 10 = compare against `xon_b`/`xoff_b`; 11 = two-character sequences `xoff_a` then `xoff_b`, and `xon_a` then `xon_b`.
- R2: In single-character modes, a received stop code sets `halted` one cycle later, and a received resume code clears it one cycle later. Neither code raises `rx_push`.
- R3: In sequence mode, the first character of a pair is pushed normally. The completing second character acts like a single match and is not pushed. Any other character between them cancels the partial match.
- R4: While `halted` is high, `data_go` is low. `halted` only gates the start of a new data byte and has no other effect on the serializer.
- R5: A stop-code match sets `xoff_irq` when `irq_en` is high. A resume match clears it, and so does an `irq_ack` pulse. With `irq_en` low, `xoff_irq` stays low.
- R6: With `xon_any_en` set while `halted` is high, any received character clears `halted` and `xoff_irq`, and is pushed into the FIFO.
- R7: With `special_en` set, a received character equal to `xoff_b` that is not a flow match sets `xoff_irq` when `irq_en` is high. It is still pushed and leaves `halted` unchanged.
- R8: `mode[3:2]` selects what is sent: 00 = nothing; 01 = `xoff_a`/`xon_a`; 10 = `xoff_b`/`xon_b`; 11 = the pair `xoff_a`,`xoff_b` or `xon_a`,`xon_b` in that order. A stop request is raised one cycle after `rx_level` exceeds `halt_lvl`.
- R9: After a stop has been sent, a resume request is raised one cycle after `rx_level` is at or below `resume_lvl`.
- R10: `ctl_char` carries only the low 5, 6, 7 or 8 bits of the code, for `word_len` = 0, 1, 2 or 3. The remaining bits read 0.
- R11: While `ctl_req` is high, `data_go` is low. `ctl_req` and `ctl_char` hold until `ctl_ack` is seen. Each `ctl_ack` advances by one character.
- R12: After reset, `halted`, `xoff_irq` and `ctl_req` are low and `data_go` follows `sh_idle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 4 | [3:2] transmit code selection, [1:0] receive matching selection |
| xon_any_en | input | 1 | Any character resumes a paused transmitter |
| special_en | input | 1 | Interrupt on `xoff_b` without pausing |
| irq_en | input | 1 | Enables setting of `xoff_irq` |
| xon_a | input | 8 | First resume code |
| xon_b | input | 8 | Second resume code |
| xoff_a | input | 8 | First stop code |
| xoff_b | input | 8 | Second stop code |
| word_len | input | 2 | Character length: 0..3 for 5..8 bits |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| rx_push | output | 1 | Write the current received character into the FIFO |
| irq_ack | input | 1 | Clears `xoff_irq` |
| rx_level | input | LVL_W | Receive FIFO fill level |
| halt_lvl | input | LVL_W | Level above which a stop code is sent |
| resume_lvl | input | LVL_W | Level at or below which a resume code is sent |
| sh_idle | input | 1 | Serializer can accept a character |
| ctl_ack | input | 1 | Serializer took `ctl_char` |
| ctl_req | output | 1 | A flow code is waiting to be sent |
| ctl_char | output | 8 | Flow code to send, trimmed to word length |
| data_go | output | 1 | Serializer may load the next data byte |
| halted | output | 1 | Transmitter paused by a received stop code |
| xoff_irq | output | 1 | Stop or special character interrupt flag |

## Verification
`rx_push` is combinational and is sampled 1 ns after the strobe is driven, within the same cycle. `halted` and `xoff_irq` change at the edge that takes the strobe, and are sampled at the falling edge that follows. `ctl_req` is registered from a threshold compare, so it is checked one full cycle after `rx_level` changes, never earlier. `ctl_char` and `data_go` are then read in the same half-cycle. Every stimulus is applied on a falling edge, so each result falls a known whole number of cycles later.

// File: rtl/xonxoff_flow_ctl.sv
module xonxoff_flow_ctl #(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       mode,
  input  logic             xon_any_en,
  input  logic             special_en,
  input  logic             irq_en,
  input  logic [7:0]       xon_a,
  input  logic [7:0]       xon_b,
  input  logic [7:0]       xoff_a,
  input  logic [7:0]       xoff_b,
  input  logic [1:0]       word_len,
  input  logic             rx_valid,
  input  logic [7:0]       rx_char,
  output logic             rx_push,
  input  logic             irq_ack,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] halt_lvl,
  input  logic [LVL_W-1:0] resume_lvl,
  input  logic             sh_idle,
  input  logic             ctl_ack,
  output logic             ctl_req,
  output logic [7:0]       ctl_char,
  output logic             data_go,
  output logic             halted,
  output logic             xoff_irq
);
  wire [1:0] rxs = mode[1:0];
  wire [1:0] txs = mode[3:2];

  logic pend_off, pend_on;
  logic off_hit, on_hit, off_first, on_first;

  always_comb begin
    off_hit = 1'b0;
    on_hit = 1'b0;
    off_first = 1'b0;
    on_first = 1'b0;
    case (rxs)
      2'd1: begin
        off_hit = rx_char == xoff_a;
        on_hit  = !off_hit && rx_char == xon_a;
      end
      2'd2: begin
        off_hit = rx_char == xoff_b;
        on_hit  = !off_hit && rx_char == xon_b;
      end
      2'd3: begin
        off_hit   = pend_off && rx_char == xoff_b;
        on_hit    = !off_hit && pend_on && rx_char == xon_b;
        off_first = !off_hit && !on_hit && rx_char == xoff_a;
        on_first  = !off_hit && !on_hit && !off_first && rx_char == xon_a;
      end
      default: ;
    endcase
  end

  wire flow_hit   = off_hit || on_hit;
  wire any_resume = xon_any_en && halted && !flow_hit;
  wire spec_hit   = special_en && !flow_hit && rx_char == xoff_b;
  wire irq_set    = rx_valid && irq_en && (off_hit || spec_hit);
  wire irq_clr    = irq_ack || (rx_valid && (on_hit || any_resume));

  assign rx_push = rx_valid && !flow_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_off <= 1'b0;
      pend_on  <= 1'b0;
      halted   <= 1'b0;
      xoff_irq <= 1'b0;
    end else begin
      if (rx_valid) begin
        pend_off <= off_first;
        pend_on  <= on_first;
        if (off_hit) halted <= 1'b1;
        else if (on_hit || any_resume) halted <= 1'b0;
      end
      if (irq_set) xoff_irq <= 1'b1;
      else if (irq_clr) xoff_irq <= 1'b0;
    end
  end

  logic remote_off, busy, seq, kind_off;
  wire want_off = txs != 2'd0 && !remote_off && rx_level > halt_lvl;
  wire want_on  = txs != 2'd0 && remote_off && rx_level <= resume_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remote_off <= 1'b0;
      busy       <= 1'b0;
      seq        <= 1'b0;
      kind_off   <= 1'b0;
    end else if (!busy) begin
      if (want_off || want_on) begin
        busy       <= 1'b1;
        seq        <= 1'b0;
        kind_off   <= want_off;
        remote_off <= want_off;
      end
    end else if (ctl_ack) begin
      if (txs == 2'd3 && !seq) seq <= 1'b1;
      else busy <= 1'b0;
    end
  end

  wire       use_b = txs == 2'd2 || seq;
  wire [7:0] raw   = use_b ? (kind_off ? xoff_b : xon_b) : (kind_off ? xoff_a : xon_a);
  wire [7:0] mask  = 8'hFF >> ~word_len;

  assign ctl_req  = busy;
  assign ctl_char = raw & mask;
  assign data_go  = sh_idle && !busy && !halted;
endmodule

module xonxoff_flow_ctl_chk #(
  parameter int LVL_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       mode,
  input logic             xon_any_en,
  input logic             special_en,
  input logic             irq_en,
  input logic [7:0]       xon_a,
  input logic [7:0]       xon_b,
  input logic [7:0]       xoff_a,
  input logic [7:0]       xoff_b,
  input logic [1:0]       word_len,
  input logic             rx_valid,
  input logic [7:0]       rx_char,
  input logic             rx_push,
  input logic             irq_ack,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] halt_lvl,
  input logic [LVL_W-1:0] resume_lvl,
  input logic             sh_idle,
  input logic             ctl_ack,
  input logic             ctl_req,
  input logic [7:0]       ctl_char,
  input logic             data_go,
  input logic             halted,
  input logic             xoff_irq
);
  AST_XOFF_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && mode[1:0] == 2'd1 && rx_char == xoff_a |=> halted);  // R2
  AST_XOFF_NOT_PUSHED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && mode[1:0] == 2'd1 && rx_char == xoff_a |-> !rx_push);  // R2
  AST_HALT_BLOCKS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !data_go);  // R4
  AST_XON_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && mode[1:0] == 2'd1 && rx_char == xon_a && rx_char != xoff_a &&
    !special_en && !irq_ack |=> !xoff_irq);  // R5
  AST_SPECIAL_PUSHED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && special_en && mode[1:0] == 2'd0 && rx_char == xoff_b |-> rx_push);  // R7
  AST_SPECIAL_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && special_en && mode[1:0] == 2'd0 && !halted && rx_char == xoff_b |=> !halted);  // R7
  AST_CTL_TRIMMED: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_req && word_len == 2'd0 |-> ctl_char[7:5] == 3'd0);  // R10
  AST_CTL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_req |-> !data_go);  // R11
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_req && !ctl_ack |=> ctl_req);  // R11
endmodule

bind xonxoff_flow_ctl xonxoff_flow_ctl_chk #(.LVL_W(LVL_W)) u_chk (.*);

// File: tb/xonxoff_flow_ctl_test.sv
module xonxoff_flow_ctl_test;
  localparam int LVL_W = 7;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] mode = 4'd0;
  logic xon_any_en = 0, special_en = 0, irq_en = 1;
  logic [7:0] xon_a = 8'hE1, xon_b = 8'hB3, xoff_a = 8'hF9, xoff_b = 8'hA7;
  logic [1:0] word_len = 2'd3;
  logic rx_valid = 0;
  logic [7:0] rx_char = 8'h00;
  logic rx_push, irq_ack = 0;
  logic [LVL_W-1:0] rx_level = '0, halt_lvl = 7'd60, resume_lvl = 7'd32;
  logic sh_idle = 1, ctl_ack = 0;
  logic ctl_req, data_go, halted, xoff_irq;
  logic [7:0] ctl_char;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  xonxoff_flow_ctl #(.LVL_W(LVL_W)) uut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic send(input logic [7:0] c, output logic pushed);
    @(negedge clk);
    rx_valid = 1;
    rx_char = c;
    #1 pushed = rx_push;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic ack();
    ctl_ack = 1;
    @(negedge clk);
    ctl_ack = 0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic p;
    logic [7:0] codes [4];
    codes[0] = xon_a; codes[1] = xon_b; codes[2] = xoff_a; codes[3] = xoff_b;

    do_reset();
    #1;
    chk("R12 halted", halted, 0);
    chk("R12 irq", xoff_irq, 0);
    chk("R12 ctl_req", ctl_req, 0);
    chk("R12 data_go", data_go, 1);

    // R1 R2 R4 R5: receive mode sweep
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 4; k++) begin
        bit matched, stop;
        matched = (m == 1 && (k == 0 || k == 2)) || (m == 2 && (k == 1 || k == 3));
        stop = matched && k >= 2;
        do_reset();
        mode = 4'(m);
        send(codes[k], p);
        chk("R1 push", p, !matched);
        chk("R2 halted", halted, stop);
        chk("R5 irq", xoff_irq, stop);
        chk("R4 data_go", data_go, !stop);
        if (stop) begin
          send(codes[k-2], p);
          chk("R2 resume no push", p, 0);
          chk("R2 resumed", halted, 0);
          chk("R5 irq cleared", xoff_irq, 0);
        end
      end
    end

    // R3: sequence mode
    do_reset();
    mode = 4'd3;
    send(xoff_a, p); chk("R3 first pushed", p, 1); chk("R3 not yet", halted, 0);
    send(xoff_b, p); chk("R3 second withheld", p, 0); chk("R3 halted", halted, 1);
    send(xon_a, p);  chk("R3 xon first pushed", p, 1);
    send(8'h55, p);  chk("R3 other pushed", p, 1);
    send(xon_b, p);  chk("R3 cancelled push", p, 1); chk("R3 cancelled halt", halted, 1);
    send(xon_a, p);
    send(xon_b, p);  chk("R3 xon withheld", p, 0); chk("R3 resumed", halted, 0);

    // R5: irq gating and ack
    do_reset();
    mode = 4'd1; irq_en = 0;
    send(xoff_a, p); chk("R5 halted no irq", halted, 1); chk("R5 irq off", xoff_irq, 0);
    do_reset();
    irq_en = 1;
    send(xoff_a, p); chk("R5 irq set", xoff_irq, 1);
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    chk("R5 ack clears", xoff_irq, 0); chk("R5 ack keeps halt", halted, 1);

    // R6: any character resumes
    do_reset();
    xon_any_en = 1;
    send(8'h41, p); chk("R6 idle push", p, 1); chk("R6 idle halted", halted, 0);
    send(xoff_a, p); chk("R6 halted", halted, 1);
    send(8'h41, p); chk("R6 push", p, 1); chk("R6 resumed", halted, 0); chk("R6 irq", xoff_irq, 0);
    xon_any_en = 0;

    // R7: special character
    do_reset();
    mode = 4'd0; special_en = 1;
    send(xoff_b, p); chk("R7 pushed", p, 1); chk("R7 no halt", halted, 0); chk("R7 irq", xoff_irq, 1);
    special_en = 0;

    // R8 R9 R10 R11: transmit sweep
    for (int t = 0; t < 4; t++) begin
      for (int wl = 0; wl < 4; wl++) begin
        int msk;
        msk = (1 << (5 + wl)) - 1;
        do_reset();
        mode = 4'(t << 2); word_len = 2'(wl);
        @(negedge clk); rx_level = 7'd60;
        @(negedge clk); chk("R8 at threshold", ctl_req, 0);
        rx_level = 7'd61;
        @(negedge clk);
        chk("R8 stop req", ctl_req, t != 0);
        if (t != 0) begin
          chk("R10 stop char", ctl_char, (t == 2 ? xoff_b : xoff_a) & msk);
          chk("R11 data blocked", data_go, 0);
          @(negedge clk); chk("R11 hold", ctl_req, 1);
          ack();
          if (t == 3) begin
            chk("R8 pair second", ctl_char, xoff_b & msk);
            ack();
          end
          chk("R11 done", ctl_req, 0);
          rx_level = 7'd40;
          @(negedge clk); chk("R9 above resume", ctl_req, 0);
          rx_level = 7'd32;
          @(negedge clk);
          chk("R9 resume req", ctl_req, 1);
          chk("R10 resume char", ctl_char, (t == 2 ? xon_b : xon_a) & msk);
          ack();
          if (t == 3) begin
            chk("R9 pair second", ctl_char, xon_b & msk);
            ack();
          end
          chk("R9 done", ctl_req, 0);
        end
        rx_level = '0;
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule